// File: doc/BRIEF.md
# UART Register Bank with Delayed Interrupts

This block gives a processor the byte-wide register view of a classic eight-register serial port. It does not model line timing. A simple bus with a 3-bit offset, read and write strobes and 8-bit data selects the registers. A write to the data offset sends the byte out as a one-cycle strobe. A read of the data offset takes the head byte from an external receive queue through a valid/pop handshake. The block keeps the interrupt-enable, line-control and modem-control state, plus one pending flag for receive and one for transmit. A single interrupt line carries the OR of the two pending flags.

No interrupt source raises its flag at once. Each source has its own countdown machine. The countdown has two states, `CD_IDLE` and `CD_RUN`, and these transitions:
- `CD_IDLE -> CD_RUN` on a start, which loads the full interval.
- `CD_RUN -> CD_RUN` on a restart, which reloads the full interval.
- `CD_RUN -> CD_IDLE` on a cancel.
- `CD_RUN -> CD_IDLE` on expiry, when the count reaches zero.

At expiry the source's enable bit is checked again, and the pending flag is set only if that bit is still on. The interval is the parameter `DELAY`, 450 clocks by default.

When line-control bit 7 is set, offsets 0 and 1 address a divisor latch that stores nothing.

Top module: `ser_regbank`

## Requirements
- R1: After reset, the enable register reads 0x00, line control reads 0x00, the identification register reads 0x01, and `irq` is low.
- R2: Offset 3 reads back the last byte written to it. Offset 1 reads back the last byte written to it while line-control bit 7 is clear.
- R3: While line-control bit 7 is set, writes to offsets 0 and 1 send nothing and leave the enable register unchanged. Reads of offsets 0 and 1 return 0x00 and pop nothing.
- R4: The identification register (offset 2 read) returns 0x00 while either pending flag is set, and 0x01 otherwise.
- R5: The line status register (offset 5) reads 0x60 (bits 6 and 5 set), with bit 0 also set while `rxq_valid` is high.
- R6: Offsets 4, 6 and 7 read 0x00. Writes to offsets 2, 4 and 7 change no readable register and no interrupt. Only a modem-control write of exactly 0x1A (loop bit 0x10 with 0x0A) stores 0x9A internally.
- R7: A data write (offset 0, line-control bit 7 clear) pulses `tx_stb` for that cycle with `tx_data` equal to the byte. It clears the transmit flag at that clock edge. If enable bit 1 is set, it restarts the transmit countdown.
- R8: A data read pops the queue when `rxq_valid` is high and returns `rxq_data`; otherwise it returns 0x00 and pops nothing. It clears the receive flag at that edge. If the queue is still non-empty on the next cycle and enable bit 0 is set, the receive countdown starts on that cycle's edge.
- R9: Writing the enable register with bit 1 set starts or reloads the transmit countdown. Writing it with bit 1 clear cancels the countdown and clears the transmit flag.
- R10: Writing the enable register with bit 0 set starts the receive countdown only if `rxq_valid` is high. Writing it with bit 0 clear cancels the countdown and clears the receive flag.
- R11: A pending flag is set exactly `DELAY` clock edges after the edge that started or last reloaded its countdown, and only if the source's enable bit is still set.
- R12: When `rxq_valid` rises while enable bit 0 is set, the receive countdown starts on the next edge.
- R13: `irq` is registered, and equals the OR of the two pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe; the read takes effect at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and state |
| rxq_valid | input | 1 | Receive queue holds at least one byte |
| rxq_data | input | 8 | Head byte of the receive queue |
| rxq_pop | output | 1 | Removes the head byte at the clock edge |
| tx_stb | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
Read data, `tx_stb`, `tx_data` and `rxq_pop` are combinational in the access cycle, so the bench samples them one time unit after driving the access, before the capturing edge. Register writes and flag clears are visible at the first falling edge after the capturing edge. The flags and `irq` rise exactly `DELAY` edges after the starting edge; for a restart that follows a data read, this is `DELAY + 1` edges after the read. The bench uses `DELAY = 8` and checks `irq` at the falling edge one cycle before the due edge, where it must still be low, and at the falling edge right after it, where it must be high.

// File: rtl/ser_regbank_pkg.sv
package ser_regbank_pkg;

    typedef enum logic {
        CD_IDLE = 1'b0,
        CD_RUN  = 1'b1
    } cd_state_e;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_IEN   = 3'd1;
    localparam logic [2:0] OFS_IDENT = 3'd2;
    localparam logic [2:0] OFS_LCTL  = 3'd3;
    localparam logic [2:0] OFS_MCTL  = 3'd4;
    localparam logic [2:0] OFS_LSTAT = 3'd5;
    localparam logic [2:0] OFS_MSTAT = 3'd6;
    localparam logic [2:0] OFS_SPARE = 3'd7;

    localparam int IEN_RX_BIT = 0;
    localparam int IEN_TX_BIT = 1;
    localparam int LCTL_LATCH_BIT = 7;

    localparam int SRC_RX = 0;
    localparam int SRC_TX = 1;
    localparam int N_SRC  = 2;

    localparam logic [7:0] LSTAT_IDLE_TX = 8'h60;
    localparam logic [7:0] IDENT_NONE    = 8'h01;
    localparam logic [7:0] IDENT_SOME    = 8'h00;
    localparam logic [7:0] MCTL_KEY      = 8'h1A;
    localparam logic [7:0] MCTL_STORED   = 8'h9A;

endpackage

// File: rtl/ser_countdown.sv
module ser_countdown
    import ser_regbank_pkg::*;
#(
    parameter int DELAY = 450
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cancel_i,
    output logic expire_o
);
    localparam int CW = (DELAY > 2) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

    cd_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CD_IDLE: begin
                if (start_i) begin
                    state_d = CD_RUN;
                    cnt_d   = LOAD;
                end
            end
            CD_RUN: begin
                if (start_i) begin
                    cnt_d = LOAD;
                end else if (cancel_i || cnt_q == '0) begin
                    state_d = CD_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = CD_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        expire_o = (state_q == CD_RUN) && (cnt_q == '0) && !start_i && !cancel_i;
    end

endmodule

// File: rtl/ser_rdmux.sv
module ser_rdmux
    import ser_regbank_pkg::*;
(
    input  logic [2:0] addr_i,
    input  logic       latch_sel_i,
    input  logic       q_valid_i,
    input  logic [7:0] q_data_i,
    input  logic [7:0] ien_i,
    input  logic [7:0] lctl_i,
    input  logic       any_pend_i,
    output logic [7:0] rdata_o
);
    always_comb begin
        rdata_o = 8'h00;
        unique case (addr_i)
            OFS_DATA:  rdata_o = (!latch_sel_i && q_valid_i) ? q_data_i : 8'h00;
            OFS_IEN:   rdata_o = latch_sel_i ? 8'h00 : ien_i;
            OFS_IDENT: rdata_o = any_pend_i ? IDENT_SOME : IDENT_NONE;
            OFS_LCTL:  rdata_o = lctl_i;
            OFS_MCTL:  rdata_o = 8'h00;
            OFS_LSTAT: rdata_o = LSTAT_IDLE_TX | {7'd0, q_valid_i};
            OFS_MSTAT: rdata_o = 8'h00;
            OFS_SPARE: rdata_o = 8'h00;
            default:   rdata_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/ser_regbank.sv
module ser_regbank
    import ser_regbank_pkg::*;
#(
    parameter int DELAY = 450
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxq_valid,
    input  logic [7:0] rxq_data,
    output logic       rxq_pop,
    output logic       tx_stb,
    output logic [7:0] tx_data,
    output logic       irq
);
    logic [7:0] ier_q, lcr_q, mcr_q;
    logic       tx_pend_q, rx_pend_q, tx_pend_d, rx_pend_d;
    logic       recheck_q, valid_q;
    logic       latch_sel, hit_data, hit_ien;
    logic       rd_data, wr_data, wr_ien;
    logic [N_SRC-1:0] tim_start, tim_cancel, tim_exp;

    // Address decode
    assign latch_sel = lcr_q[LCTL_LATCH_BIT];
    assign hit_data  = (bus_addr == OFS_DATA) && !latch_sel;
    assign hit_ien   = (bus_addr == OFS_IEN)  && !latch_sel;
    assign rd_data   = bus_rd && hit_data;
    assign wr_data   = bus_wr && hit_data;
    assign wr_ien    = bus_wr && hit_ien;

    assign rxq_pop = rd_data && rxq_valid;
    assign tx_stb  = wr_data;
    assign tx_data = bus_wdata;

    // Countdown control
    always_comb begin
        tim_start[SRC_TX]  = (wr_ien && bus_wdata[IEN_TX_BIT]) ||
                             (wr_data && ier_q[IEN_TX_BIT]);
        tim_cancel[SRC_TX] = wr_ien && !bus_wdata[IEN_TX_BIT];
        tim_start[SRC_RX]  = (wr_ien && bus_wdata[IEN_RX_BIT] && rxq_valid) ||
                             (!wr_ien && ier_q[IEN_RX_BIT] && rxq_valid &&
                              (recheck_q || !valid_q));
        tim_cancel[SRC_RX] = wr_ien && !bus_wdata[IEN_RX_BIT];
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        ser_countdown #(.DELAY(DELAY)) u_cd (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (tim_start[s]),
            .cancel_i (tim_cancel[s]),
            .expire_o (tim_exp[s])
        );
    end

    // Pending flags
    always_comb begin
        tx_pend_d = tx_pend_q;
        if (wr_data || tim_cancel[SRC_TX])
            tx_pend_d = 1'b0;
        else if (tim_exp[SRC_TX] && ier_q[IEN_TX_BIT])
            tx_pend_d = 1'b1;

        rx_pend_d = rx_pend_q;
        if (rd_data || tim_cancel[SRC_RX])
            rx_pend_d = 1'b0;
        else if (tim_exp[SRC_RX] && ier_q[IEN_RX_BIT])
            rx_pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_q     <= 8'h00;
            lcr_q     <= 8'h00;
            mcr_q     <= 8'h00;
            tx_pend_q <= 1'b0;
            rx_pend_q <= 1'b0;
            irq       <= 1'b0;
            recheck_q <= 1'b0;
            valid_q   <= 1'b0;
        end else begin
            if (wr_ien)
                ier_q <= bus_wdata;
            if (bus_wr && bus_addr == OFS_LCTL)
                lcr_q <= bus_wdata;
            if (bus_wr && bus_addr == OFS_MCTL && bus_wdata == MCTL_KEY)
                mcr_q <= MCTL_STORED;
            tx_pend_q <= tx_pend_d;
            rx_pend_q <= rx_pend_d;
            irq       <= tx_pend_d | rx_pend_d;
            recheck_q <= rd_data;
            valid_q   <= rxq_valid;
        end
    end

    ser_rdmux u_rdmux (
        .addr_i      (bus_addr),
        .latch_sel_i (latch_sel),
        .q_valid_i   (rxq_valid),
        .q_data_i    (rxq_data),
        .ien_i       (ier_q),
        .lctl_i      (lcr_q),
        .any_pend_i  (tx_pend_q | rx_pend_q),
        .rdata_o     (bus_rdata)
    );

endmodule

// File: rtl/ser_regbank_chk.sv
module ser_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       tx_stb,
    input logic       rxq_pop,
    input logic       rxq_valid,
    input logic       irq,
    input logic       tx_pend_q,
    input logic       rx_pend_q,
    input logic [7:0] ier_q,
    input logic [7:0] lcr_q,
    input logic [7:0] mcr_q,
    input logic [1:0] tim_exp
);
    assert_irq_or_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (tx_pend_q | rx_pend_q));

    assert_pop_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_pop |-> rxq_valid);

    assert_tx_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pend_q) |-> ($past(tim_exp[1]) && $past(ier_q[1])));

    assert_rx_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_pend_q) |-> ($past(tim_exp[0]) && $past(ier_q[0])));

    assert_latch_ien_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr <= 3'd1 && lcr_q[7]) |=> $stable(ier_q));

    assert_mctl_vals_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mcr_q == 8'h00) || (mcr_q == 8'h9A));

    assert_tx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |=> !tx_pend_q);

    assert_ien_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1 && !lcr_q[7] && !bus_wdata[1]) |=> !tx_pend_q);
endmodule

bind ser_regbank ser_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .tx_stb    (tx_stb),
    .rxq_pop   (rxq_pop),
    .rxq_valid (rxq_valid),
    .irq       (irq),
    .tx_pend_q (tx_pend_q),
    .rx_pend_q (rx_pend_q),
    .ier_q     (ier_q),
    .lcr_q     (lcr_q),
    .mcr_q     (mcr_q),
    .tim_exp   (tim_exp)
);

// File: tb/sim_ser_regbank.sv
`timescale 1ns/1ps
module sim_ser_regbank;
    localparam int D = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rxq_valid;
    logic [7:0] rxq_data;
    logic       rxq_pop;
    logic       tx_stb;
    logic [7:0] tx_data;
    logic       irq;

    logic [7:0] q [16];
    logic [3:0] hd = 4'd0;
    logic [3:0] tl = 4'd0;
    int checks = 0;
    int errors = 0;
    int tx_cnt = 0;
    int pop_cnt = 0;
    logic [7:0] tx_last = 8'h00;
    logic [7:0] rv;
    bit done = 0;

    always #5 clk = ~clk;

    assign rxq_valid = (hd != tl);
    assign rxq_data  = q[hd];

    ser_regbank #(.DELAY(D)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxq_valid(rxq_valid), .rxq_data(rxq_data), .rxq_pop(rxq_pop),
        .tx_stb(tx_stb), .tx_data(tx_data), .irq(irq)
    );

    always @(posedge clk) begin
        if (rxq_pop) begin
            hd <= hd + 4'd1;
            pop_cnt = pop_cnt + 1;
        end
        if (tx_stb) begin
            tx_cnt = tx_cnt + 1;
            tx_last = tx_data;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        q[tl] = b;
        tl = tl + 4'd1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", irq, 0);
        rd(3'd1, rv); chk("R1 ien", rv, 8'h00);
        rd(3'd3, rv); chk("R1 lctl", rv, 8'h00);
        rd(3'd2, rv); chk("R1 ident", rv, 8'h01);
        rd(3'd5, rv); chk("R5 lstat empty", rv, 8'h60);

        // R2 line control sweep, enable readback
        for (int v = 0; v < 256; v++) begin
            wr(3'd3, 8'(v)); rd(3'd3, rv); chk("R2 lctl", rv, v);
        end
        wr(3'd3, 8'h00);
        wr(3'd1, 8'hF0); rd(3'd1, rv); chk("R2 ien", rv, 8'hF0);

        // R6 fixed reads, ignored writes, modem-control sweep
        wr(3'd7, 8'hFF); wr(3'd2, 8'hFF);
        for (int v = 0; v < 256; v++) begin
            wr(3'd4, 8'(v)); rd(3'd4, rv); chk("R6 mctl", rv, 0);
        end
        rd(3'd6, rv); chk("R6 mstat", rv, 0);
        rd(3'd7, rv); chk("R6 spare", rv, 0);
        rd(3'd1, rv); chk("R6 ien kept", rv, 8'hF0);
        rd(3'd3, rv); chk("R6 lctl kept", rv, 8'h00);
        chk("R6 irq", irq, 0);

        // R3 divisor latch window
        wr(3'd1, 8'h0C);
        wr(3'd3, 8'h80);
        t0 = tx_cnt; p0 = pop_cnt;
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'h55);
        push(8'h11); @(negedge clk);
        rd(3'd0, rv); chk("R3 data read", rv, 0);
        rd(3'd1, rv); chk("R3 ien read", rv, 0);
        chk("R3 no send", tx_cnt, t0);
        chk("R3 no pop", pop_cnt, p0);
        idle(2 * D);
        chk("R3 no irq", irq, 0);
        wr(3'd3, 8'h03);
        rd(3'd1, rv); chk("R3 ien kept", rv, 8'h0C);
        rd(3'd0, rv); chk("R8 drain", rv, 8'h11);

        // R9 / R11 transmit countdown
        wr(3'd1, 8'h02);
        idle(D - 1); chk("R11 tx early", irq, 0);
        idle(1);     chk("R11 tx due", irq, 1);
        rd(3'd2, rv); chk("R4 ident some", rv, 8'h00);
        // R7 data write
        t0 = tx_cnt;
        wr(3'd0, 8'h3C);
        chk("R7 strobe", tx_cnt, t0 + 1);
        chk("R7 byte", tx_last, 8'h3C);
        chk("R7 clear", irq, 0);
        idle(D - 1); chk("R7 restart early", irq, 0);
        idle(1);     chk("R7 restart due", irq, 1);
        wr(3'd1, 8'h00);
        chk("R9 clear", irq, 0);
        rd(3'd2, rv); chk("R4 ident none", rv, 8'h01);

        // R11 reload on restart
        wr(3'd1, 8'h02);
        idle(3);
        wr(3'd1, 8'h02);
        idle(4);     chk("R11 old expiry", irq, 0);
        idle(D - 5); chk("R11 reload early", irq, 0);
        idle(1);     chk("R11 reload due", irq, 1);
        wr(3'd1, 8'h00);

        // R9 cancel
        wr(3'd1, 8'h02);
        idle(3);
        wr(3'd1, 8'h00);
        idle(2 * D); chk("R9 cancel", irq, 0);

        // R10 receive start, R8 read and recheck
        push(8'hA5); push(8'h5A);
        idle(2 * D); chk("R10 no enable", irq, 0);
        rd(3'd5, rv); chk("R5 lstat data", rv, 8'h61);
        wr(3'd1, 8'h01);
        idle(D - 1); chk("R10 rx early", irq, 0);
        idle(1);     chk("R10 rx due", irq, 1);
        rd(3'd0, rv); chk("R8 byte1", rv, 8'hA5);
        chk("R8 clear", irq, 0);
        idle(D);     chk("R8 recheck early", irq, 0);
        idle(1);     chk("R8 recheck due", irq, 1);
        rd(3'd0, rv); chk("R8 byte2", rv, 8'h5A);
        idle(2 * D); chk("R8 empty no restart", irq, 0);
        p0 = pop_cnt;
        rd(3'd0, rv); chk("R8 empty read", rv, 0);
        chk("R8 empty no pop", pop_cnt, p0);

        // R12 arrival while enabled
        push(8'h77);
        idle(D);     chk("R12 early", irq, 0);
        idle(1);     chk("R12 due", irq, 1);
        wr(3'd1, 8'h00);
        chk("R10 clear", irq, 0);
        rd(3'd0, rv); chk("R8 drain2", rv, 8'h77);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule